// File: doc/BRIEF.md
# Per-Initiator In-Order Request Sequencer

This block sits in front of a memory target on a packet-switched interconnect. Requests reach it from several initiators, and each request carries a source number and a 3-bit tag. Routes through the network may differ, so requests from one source can arrive in a different order from the one they were issued in. The block keeps one expected-tag counter per source. A request whose tag matches its source's counter is released to the memory. A request that arrives early waits in a shared reorder store until the requests before it have been released. Requests from different sources are never ordered against each other.

Each released request produces exactly one registered response in the next cycle. For a write, the response carries an acknowledge flag. For a read, it carries the data read. Both kinds return the source number and the tag. When the reorder store is full and the incoming request cannot go straight to the memory, the input is stalled and the request is kept, never dropped. A round-robin arbiter picks one release per cycle among the sources that have their expected request available, either in the store or on the input.

Top module: `inorder_sequencer`

## Requirements
- R1: While reset is held and right after it, `rsp_valid` is 0, `req_ready` is 1, and every source's expected tag is 0.
- R2: For each source, responses come out in strictly increasing tag order, modulo 8. A request whose tag is not the expected one produces no response until all earlier tags of its source have been released.
- R3: Early requests are held in an 8-entry store shared by all sources. `req_ready` is 0 only when the store is full and the incoming request is not released in that same cycle.
- R4: No request is dropped. Every accepted request produces exactly one response, and a release in one cycle raises `rsp_valid` in the next cycle.
- R5: A write response has `rsp_wr`=1 and `rsp_ack`=1 and echoes the source and tag. The written word is visible to later reads.
- R6: A read response has `rsp_wr`=0 and `rsp_ack`=0, echoes the source and tag, and returns in `rsp_rdata` the memory word at `req_addr` as left by all earlier releases.
- R7: An incoming request whose tag is the expected one, and which wins arbitration, bypasses the store. It is accepted in that cycle even when the store is full, and its response is valid right after that same clock edge.
- R8: When several sources have their expected request available, the grant goes to the first such source after the one granted last, counting upward with wrap-around. The pointer starts at source 3, so source 0 has first priority after reset.
- R9: Tags wrap: after tag 7, the next tag a source expects is 0.
- R10: A source whose expected request is present is released even while other sources are blocked waiting for missing tags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this clock edge |
| req_src | input | 2 | Source (initiator) number |
| req_tag | input | 3 | Per-source sequence tag, modulo 8 |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_src | output | 2 | Source of the answered request |
| rsp_tag | output | 3 | Tag of the answered request |
| rsp_wr | output | 1 | Answered request was a write |
| rsp_ack | output | 1 | Write acknowledge |
| rsp_rdata | output | 8 | Read data (0 for writes) |

## Verification
Two things can happen in the same cycle: a request on the input that is eligible to bypass, and an entry already in the store that has become releasable for a different source. Only one of them can be granted. The bench provokes this by loading the store with the two tags after the expected one for three sources, then sending the missing tags back to back. The resulting response order, in which the incoming request and the stored ones take turns, is compared with a rotating source sequence computed from the round-robin rule. A second collision, a bypass while the store is full, is set up by filling all eight entries with requests that cannot yet be released.

// File: rtl/seqr_pkg.sv
package seqr_pkg;
    localparam int INIT_W = 2;
    localparam int TAG_W  = 3;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    typedef struct packed {
        logic [INIT_W-1:0] src;
        logic [TAG_W-1:0]  tag;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } req_t;
endpackage

// File: rtl/seqr_rob.sv
module seqr_rob
    import seqr_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int NSRC  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  req_t                         push_req,
    input  logic                         pop,
    input  logic [IDX_W-1:0]             pop_idx,
    input  logic [NSRC-1:0][TAG_W-1:0]   exp_tag,
    output logic                         has_free,
    output logic [NSRC-1:0]              hit,
    output logic [NSRC-1:0][IDX_W-1:0]   hit_idx,
    output req_t                         pop_req
);
    typedef struct packed {
        logic vld;
        req_t req;
    } slot_t;

    slot_t [DEPTH-1:0] slot_q, slot_d;
    logic  [IDX_W-1:0] free_idx;

    // lowest free slot
    always_comb begin
        has_free = 1'b0;
        free_idx = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (!slot_q[k].vld) begin
                has_free = 1'b1;
                free_idx = IDX_W'(k);
            end
        end
    end

    // per-source search for the expected tag
    always_comb begin
        hit     = '0;
        hit_idx = '0;
        for (int s = 0; s < NSRC; s++) begin
            for (int k = DEPTH - 1; k >= 0; k--) begin
                if (slot_q[k].vld && slot_q[k].req.src == INIT_W'(s)
                    && slot_q[k].req.tag == exp_tag[s]) begin
                    hit[s]     = 1'b1;
                    hit_idx[s] = IDX_W'(k);
                end
            end
        end
    end

    assign pop_req = slot_q[pop_idx].req;

    always_comb begin
        slot_d = slot_q;
        if (pop) begin
            slot_d[pop_idx].vld = 1'b0;
        end
        if (push) begin
            slot_d[free_idx].vld = 1'b1;
            slot_d[free_idx].req = push_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> has_free); // R3
    AST_POP_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> slot_q[pop_idx].vld); // R4
endmodule

// File: rtl/seqr_rr.sv
module seqr_rr #(
    parameter int N = 4,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    output logic          gnt_any,
    output logic [IW-1:0] gnt_idx
);
    logic [IW-1:0] ptr_q, ptr_d;
    logic [IW-1:0] idx;

    always_comb begin
        gnt_any = 1'b0;
        gnt_idx = ptr_q;
        idx     = '0;
        // k = N is the last-granted source itself: lowest priority
        for (int k = N; k >= 1; k--) begin
            idx = IW'((int'(ptr_q) + k) % N);
            if (req[idx]) begin
                gnt_any = 1'b1;
                gnt_idx = idx;
            end
        end
        ptr_d = gnt_any ? gnt_idx : ptr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= IW'(N - 1);
        end else begin
            ptr_q <= ptr_d;
        end
    end

    AST_GNT_IS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_any |-> req[gnt_idx]); // R8
    AST_REPEAT_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_any && gnt_idx == ptr_q) |-> $countones(req) == 1); // R8
endmodule

// File: rtl/seqr_mem.sv
module seqr_mem
    import seqr_pkg::*;
#(
    localparam int WORDS = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [WORDS-1:0][DATA_W-1:0] mem_q, mem_d;

    assign rdata = mem_q[addr];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[addr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end
endmodule

// File: rtl/inorder_sequencer.sv
module inorder_sequencer
    import seqr_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int NSRC  = 1 << INIT_W,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [INIT_W-1:0] req_src,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [INIT_W-1:0] rsp_src,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic              rsp_wr,
    output logic              rsp_ack,
    output logic [DATA_W-1:0] rsp_rdata
);
    typedef struct packed {
        logic [NSRC-1:0][TAG_W-1:0] exp;
        logic                       rv;
        logic [INIT_W-1:0]          rsrc;
        logic [TAG_W-1:0]           rtag;
        logic                       rwr;
        logic                       rack;
        logic [DATA_W-1:0]          rdata;
    } st_t;

    st_t st_q, st_d;

    req_t                       in_req, pop_req, rel;
    logic                       in_order, use_buf, bypass, push, pop;
    logic                       rob_free, gnt_any;
    logic [NSRC-1:0]            rob_hit, cand;
    logic [NSRC-1:0][IDX_W-1:0] rob_hit_idx;
    logic [INIT_W-1:0]          gnt_idx;
    logic [DATA_W-1:0]          mem_rdata;

    assign in_req   = '{src: req_src, tag: req_tag, wr: req_wr,
                        addr: req_addr, data: req_wdata};
    assign in_order = req_valid && (req_tag == st_q.exp[req_src]);

    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            cand[s] = rob_hit[s] || (in_order && req_src == INIT_W'(s));
        end
    end

    seqr_rr #(.N(NSRC)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (cand),
        .gnt_any (gnt_any),
        .gnt_idx (gnt_idx)
    );

    assign use_buf   = rob_hit[gnt_idx];
    assign bypass    = gnt_any && !use_buf;
    assign pop       = gnt_any && use_buf;
    assign req_ready = bypass || rob_free;
    assign push      = req_valid && rob_free && !bypass;
    assign rel       = use_buf ? pop_req : in_req;

    seqr_rob #(.DEPTH(DEPTH), .NSRC(NSRC)) u_rob (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_req (in_req),
        .pop      (pop),
        .pop_idx  (rob_hit_idx[gnt_idx]),
        .exp_tag  (st_q.exp),
        .has_free (rob_free),
        .hit      (rob_hit),
        .hit_idx  (rob_hit_idx),
        .pop_req  (pop_req)
    );

    seqr_mem u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (gnt_any && rel.wr),
        .addr  (rel.addr),
        .wdata (rel.data),
        .rdata (mem_rdata)
    );

    always_comb begin
        st_d    = st_q;
        st_d.rv = gnt_any;
        if (gnt_any) begin
            st_d.exp[gnt_idx] = st_q.exp[gnt_idx] + TAG_W'(1);
            st_d.rsrc         = rel.src;
            st_d.rtag         = rel.tag;
            st_d.rwr          = rel.wr;
            st_d.rack         = rel.wr;
            st_d.rdata        = rel.wr ? '0 : mem_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rv;
    assign rsp_src   = st_q.rsrc;
    assign rsp_tag   = st_q.rtag;
    assign rsp_wr    = st_q.rwr;
    assign rsp_ack   = st_q.rack;
    assign rsp_rdata = st_q.rdata;

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_any |=> rsp_valid); // R4
    AST_RSP_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (TAG_W'(rsp_tag + TAG_W'(1)) == st_q.exp[rsp_src])); // R2
    AST_ACK_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_ack == rsp_wr)); // R5
    AST_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |-> !rob_free); // R3
endmodule

// File: tb/tb_inorder_sequencer.sv
module tb_inorder_sequencer;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [1:0] req_src = '0;
    logic [2:0] req_tag = '0;
    logic       req_wr = 1'b0;
    logic [3:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic       rsp_valid;
    logic [1:0] rsp_src;
    logic [2:0] rsp_tag;
    logic       rsp_wr;
    logic       rsp_ack;
    logic [7:0] rsp_rdata;

    always #(CLK_P / 2) clk = ~clk;

    inorder_sequencer dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_src(req_src), .req_tag(req_tag), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_src(rsp_src), .rsp_tag(rsp_tag),
        .rsp_wr(rsp_wr), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit t_wr[4][8];
    int t_addr[4][8];
    int t_data[4][8];
    int mmem[16];
    int mexp[4];
    int rcnt[4];
    bit saw_wrap[4];
    int nxt[4];
    int log_src[512];
    int log_n = 0;
    int total_sent = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // response checker: order, kind, data from a bench memory model
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            int s;
            int e;
            s = int'(rsp_src);
            e = mexp[s];
            chk(int'(rsp_tag) == e, "R2 tag order", int'(rsp_tag), e);
            if (t_wr[s][e]) begin
                chk(rsp_wr && rsp_ack, "R5 write ack", {30'd0, rsp_wr, rsp_ack}, 3);
                mmem[t_addr[s][e]] = t_data[s][e];
            end else begin
                chk(!rsp_wr && !rsp_ack, "R6 read flags", {30'd0, rsp_wr, rsp_ack}, 0);
                chk(int'(rsp_rdata) == mmem[t_addr[s][e]], "R6 read data",
                    int'(rsp_rdata), mmem[t_addr[s][e]]);
            end
            if (e == 0 && rcnt[s] > 0) saw_wrap[s] = 1'b1; // R9
            mexp[s] = (e + 1) % 8;
            rcnt[s]++;
            if (log_n < 512) log_src[log_n] = s;
            log_n++;
        end
    end

    task automatic send(input int s, input int tag, input bit wr, input int addr, input int data);
        t_wr[s][tag % 8]   = wr;
        t_addr[s][tag % 8] = addr;
        t_data[s][tag % 8] = data;
        req_valid = 1'b1;
        req_src   = 2'(s);
        req_tag   = 3'(tag % 8);
        req_wr    = wr;
        req_addr  = 4'(addr);
        req_wdata = 8'(data);
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        total_sent++;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int start;
        for (int i = 0; i < 4; i++) begin
            mexp[i] = 0; rcnt[i] = 0; saw_wrap[i] = 0; nxt[i] = 0;
        end
        for (int a = 0; a < 16; a++) mmem[a] = 0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!rsp_valid, "R1 rsp_valid in reset", int'(rsp_valid), 0);
        chk(req_ready, "R1 ready in reset", int'(req_ready), 1);
        rst_n = 1'b1;
        idle(1);
        chk(!rsp_valid, "R1 rsp_valid after reset", int'(rsp_valid), 0);

        // R7: tag 0 bypasses, response right after the accepting edge
        send(0, 0, 1'b1, 0, 8'h11);
        chk(rsp_valid && rsp_src == 2'd0 && rsp_tag == 3'd0, "R7 bypass latency",
            int'(rsp_valid), 1);
        send(0, 1, 1'b0, 0, 0);
        idle(2);
        chk(rcnt[0] == 2, "R5/R6 write then read", rcnt[0], 2);
        nxt[0] = 2;

        // R2/R3/R9: permuted windows of four tags per source
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 4; i++) begin
                start = rcnt[i];
                for (int j = 0; j < 4; j++) begin
                    int off;
                    off = (j * 3 + p) % 4;
                    if (off == 0)
                        chk(rcnt[i] == start, "R2 early tags held", rcnt[i], start);
                    send(i, nxt[i] + off, ((j + p) % 2) == 0, i * 4 + j,
                         (i * 37 + j * 11 + p * 5) % 256);
                end
                idle(8);
                chk(rcnt[i] == start + 4, "R3 buffered released", rcnt[i], start + 4);
                nxt[i] = (nxt[i] + 4) % 8;
            end
        end

        // R3/R7/R10: fill the store, then stall and bypass
        for (int k = 1; k <= 7; k++) send(1, nxt[1] + k, (k % 2) == 1, 4 + (k % 4), k * 9);
        send(2, nxt[2] + 1, 1'b0, 8, 0);
        start = log_n;
        req_valid = 1'b1; req_src = 2'd3; req_tag = 3'((nxt[3] + 1) % 8);
        req_wr = 1'b0; req_addr = 4'd12;
        #1;
        chk(!req_ready, "R3 stall when full", int'(req_ready), 0);
        @(negedge clk);
        req_valid = 1'b0;
        idle(2);
        chk(log_n == start, "R3 no release while blocked", log_n, start);
        start = rcnt[3];
        send(3, nxt[3], 1'b1, 13, 8'h5a);
        chk(rsp_valid && rsp_src == 2'd3, "R7 bypass while full", int'(rsp_valid), 1);
        idle(2);
        chk(rcnt[3] == start + 1, "R10 other sources blocked", rcnt[3], start + 1);
        nxt[3] = (nxt[3] + 1) % 8;
        start = rcnt[1];
        send(1, nxt[1], 1'b0, 5, 0);
        idle(12);
        chk(rcnt[1] == start + 8, "R4 full store drained", rcnt[1], start + 8);
        nxt[1] = nxt[1];
        start = rcnt[2];
        send(2, nxt[2], 1'b1, 9, 8'h77);
        idle(4);
        chk(rcnt[2] == start + 2, "R4 source 2 drained", rcnt[2], start + 2);
        nxt[2] = (nxt[2] + 2) % 8;

        // R8: round robin, incoming request competing with stored ones
        send(3, nxt[3], 1'b0, 13, 0);
        idle(2);
        nxt[3] = (nxt[3] + 1) % 8;
        for (int i = 0; i < 3; i++) begin
            send(i, nxt[i] + 1, 1'b1, i * 4 + 1, 40 + i);
            send(i, nxt[i] + 2, 1'b0, i * 4 + 1, 0);
        end
        start = log_n;
        for (int i = 0; i < 3; i++) send(i, nxt[i], 1'b0, i * 4 + 2, 0);
        idle(15);
        chk(log_n == start + 9, "R8 all released", log_n, start + 9);
        for (int k = 0; k < 9; k++)
            chk(log_src[start + k] == k % 3, "R8 rotation", log_src[start + k], k % 3);

        // R4/R9 totals
        chk(log_n == total_sent, "R4 one response per request", log_n, total_sent);
        for (int i = 0; i < 4; i++)
            chk(saw_wrap[i], "R9 tag wrap", int'(saw_wrap[i]), 1);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule